// File: doc/BRIEF.md
# Hub Downstream Port Power Manager

This block controls the power switch and the status indicator of every downstream port of a hub. Host requests reach it as one-cycle strobes per port: switch power on, switch power off, and acknowledge an overcurrent change. Power is applied only when the hub is configured and a switch-on strobe arrives. Power is removed on reset, on a re-enumeration event, on a switch-off strobe, or whenever that port reports an overcurrent.

Each raw overcurrent input passes through a two-flop synchronizer and a stability filter before the block acts on it. A filtered overcurrent does three things: it sets a status bit that follows the filtered level, it sets a sticky change bit that the host must clear, and it makes the port's indicator blink with a period set by a parameter. The indicator blinks until the host switches that port off or the hub is re-enumerated. When the indicator is not blinking it shows the port-enabled flag. The clock is taken to be 12 MHz, so the default blink half-period of 6,000,000 cycles gives a period of about one second.

Top module: `hub_port_power`

## Requirements
- R1: After reset all outputs are 0 (power off, indicator off, status and change bits clear).
- R2: A port's power output goes to 1 only one cycle after a switch-on strobe for that port while `hub_cfg` is 1. A switch-on strobe while `hub_cfg` is 0 has no effect.
- R3: A switch-off strobe or a `reenum` pulse drives the power output to 0 on the next cycle, and wins over a switch-on strobe in the same cycle.
- R4: `oc_in` passes through two synchronizing flops and is acted on only after the synchronized value has differed from the filtered level for FILT_CYCLES consecutive cycles. A shorter pulse leaves status, change, power and indicator unchanged.
- R5: While the filtered overcurrent is 1, the port's power output is 0 from the next cycle on, and switch-on strobes are ignored.
- R6: `oc_status` equals the filtered overcurrent level, so it returns to 0 after the input has been low for the filter time.
- R7: `oc_change` is set one cycle after the filtered level rises and stays 1 until a `clr_oc_chg` strobe for that port. A rise in the same cycle as a clear strobe leaves the bit set.
- R8: One cycle after the filtered level rises the indicator turns on. It then toggles every BLINK_HALF cycles.
- R9: Blinking stops one cycle after a switch-off strobe or a `reenum` pulse. The indicator then follows `port_en`.
- R10: When the port is not blinking, `stat_led` equals `port_en`. A port that becomes disabled turns its indicator off at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (12 MHz assumed) |
| rst_n | input | 1 | Active-low hub reset / power-up |
| hub_cfg | input | 1 | Hub has been configured by the host |
| reenum | input | 1 | One-cycle re-enumeration event |
| set_pwr | input | NPORTS | Per-port switch-on request strobe |
| clr_pwr | input | NPORTS | Per-port switch-off request strobe |
| clr_oc_chg | input | NPORTS | Per-port overcurrent-change clear strobe |
| oc_in | input | NPORTS | Raw asynchronous overcurrent inputs, high active |
| port_en | input | NPORTS | Port-enabled flag from the port logic |
| pwr_on | output | NPORTS | Power-switch enable per port |
| stat_led | output | NPORTS | Status indicator per port |
| oc_status | output | NPORTS | Filtered overcurrent level per port |
| oc_change | output | NPORTS | Sticky overcurrent change bit per port |

## Verification
The bench builds the block with four ports, FILT_CYCLES of 4 and BLINK_HALF of 8. The short half-period lets several complete blink periods run within a few dozen cycles, so the toggle boundaries and the restart of the blink phase can all be observed. The four-cycle filter makes a three-cycle glitch and a held overcurrent fall on the two sides of the threshold. Both parameters are small enough that overcurrents overlapping across ports, clear strobes landing on the same cycle as a rise, and blink cancellation all fit in one short run.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef struct packed {
    logic pwr;
    logic led;
    logic oc_st;
    logic oc_chg;
  } port_out_t;
endpackage

// File: rtl/hpm_oc_filter.sv
module hpm_oc_filter #(
  parameter int FILT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_raw,
  output logic oc_lvl
);
  localparam int FW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

  logic sync1, sync2;
  logic [FW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= oc_raw;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_lvl  <= 1'b0;
      run_cnt <= '0;
    end else if (sync2 == oc_lvl) begin
      run_cnt <= '0;
    end else if (run_cnt == LAST) begin
      oc_lvl  <= sync2;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  // R4: the filtered level only moves to a value the synchronizer held
  assert_lvl_from_sync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_lvl != $past(oc_lvl)) |-> (oc_lvl == $past(sync2)));
endmodule

// File: rtl/hpm_blink_gen.sv
module hpm_blink_gen #(
  parameter int BLINK_HALF = 6000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic phase
);
  localparam int BW = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLINK_HALF - 1);

  logic [BW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= '0;
      phase <= 1'b0;
    end else if (start) begin
      tick  <= '0;
      phase <= 1'b1;
    end else if (!run) begin
      tick  <= '0;
      phase <= 1'b0;
    end else if (tick == LAST) begin
      tick  <= '0;
      phase <= ~phase;
    end else begin
      tick <= tick + 1'b1;
    end
  end

  // R8: while running, the phase flips only at the end of a half-period
  assert_toggle_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(start) && (phase != $past(phase))) |-> ($past(tick) == LAST));
endmodule

// File: rtl/hpm_port_slice.sv
module hpm_port_slice #(
  parameter int FILT_CYCLES = 4,
  parameter int BLINK_HALF  = 6000000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hub_cfg,
  input  logic                reenum,
  input  logic                set_req,
  input  logic                clr_req,
  input  logic                clr_chg,
  input  logic                oc_raw,
  input  logic                port_en,
  output hpm_pkg::port_out_t  po
);
  logic oc_lvl, oc_lvl_d, oc_rise;
  logic pwr_q, chg_q, blink_q, phase;
  logic drop_pwr;

  hpm_oc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .rst_n(rst_n), .oc_raw(oc_raw), .oc_lvl(oc_lvl)
  );

  hpm_blink_gen #(.BLINK_HALF(BLINK_HALF)) u_blink (
    .clk(clk), .rst_n(rst_n), .start(oc_rise), .run(blink_q), .phase(phase)
  );

  assign oc_rise  = oc_lvl & ~oc_lvl_d;
  assign drop_pwr = clr_req | reenum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_lvl_d <= 1'b0;
      pwr_q    <= 1'b0;
      chg_q    <= 1'b0;
      blink_q  <= 1'b0;
    end else begin
      oc_lvl_d <= oc_lvl;
      if (oc_lvl || drop_pwr)      pwr_q <= 1'b0;
      else if (set_req && hub_cfg) pwr_q <= 1'b1;
      if (oc_rise)      chg_q <= 1'b1;
      else if (clr_chg) chg_q <= 1'b0;
      if (oc_rise)       blink_q <= 1'b1;
      else if (drop_pwr) blink_q <= 1'b0;
    end
  end

  always_comb begin
    po.pwr    = pwr_q;
    po.led    = blink_q ? phase : port_en;
    po.oc_st  = oc_lvl;
    po.oc_chg = chg_q;
  end

  assert_pwr_needs_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_q && !$past(pwr_q)) |-> $past(set_req && hub_cfg));
  assert_pwr_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pwr |=> !pwr_q);
  assert_oc_kills_pwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oc_lvl |=> !pwr_q);
  assert_rise_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    oc_rise |=> (chg_q && blink_q));
  assert_blink_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_pwr && !oc_rise) |=> !blink_q);
endmodule

// File: rtl/hub_port_power.sv
module hub_port_power #(
  parameter int NPORTS      = 4,
  parameter int FILT_CYCLES = 4,
  parameter int BLINK_HALF  = 6000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hub_cfg,
  input  logic              reenum,
  input  logic [NPORTS-1:0] set_pwr,
  input  logic [NPORTS-1:0] clr_pwr,
  input  logic [NPORTS-1:0] clr_oc_chg,
  input  logic [NPORTS-1:0] oc_in,
  input  logic [NPORTS-1:0] port_en,
  output logic [NPORTS-1:0] pwr_on,
  output logic [NPORTS-1:0] stat_led,
  output logic [NPORTS-1:0] oc_status,
  output logic [NPORTS-1:0] oc_change
);
  hpm_pkg::port_out_t po [NPORTS];

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    hpm_port_slice #(.FILT_CYCLES(FILT_CYCLES), .BLINK_HALF(BLINK_HALF)) u_slice (
      .clk(clk), .rst_n(rst_n), .hub_cfg(hub_cfg), .reenum(reenum),
      .set_req(set_pwr[p]), .clr_req(clr_pwr[p]), .clr_chg(clr_oc_chg[p]),
      .oc_raw(oc_in[p]), .port_en(port_en[p]), .po(po[p])
    );
    assign pwr_on[p]    = po[p].pwr;
    assign stat_led[p]  = po[p].led;
    assign oc_status[p] = po[p].oc_st;
    assign oc_change[p] = po[p].oc_chg;
  end

  assert_reenum_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reenum |=> (pwr_on == '0));
endmodule

// File: tb/tb_hub_port_power.sv
module tb_hub_port_power;
  localparam int N = 4;
  localparam int F = 4;
  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hub_cfg = 1'b0;
  logic reenum = 1'b0;
  logic [N-1:0] set_pwr = '0, clr_pwr = '0, clr_oc_chg = '0, oc_in = '0, port_en = '0;
  logic [N-1:0] pwr_on, stat_led, oc_status, oc_change;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string cur_req = "R1";

  hub_port_power #(.NPORTS(N), .FILT_CYCLES(F), .BLINK_HALF(H)) dut (
    .clk(clk), .rst_n(rst_n), .hub_cfg(hub_cfg), .reenum(reenum),
    .set_pwr(set_pwr), .clr_pwr(clr_pwr), .clr_oc_chg(clr_oc_chg),
    .oc_in(oc_in), .port_en(port_en), .pwr_on(pwr_on), .stat_led(stat_led),
    .oc_status(oc_status), .oc_change(oc_change)
  );

  always #4 clk = ~clk;

  // Behavioural reference: per-port integers updated once per clock
  int m_s1[N], m_s2[N], m_lvl[N], m_run[N], m_prev[N];
  int m_pwr[N], m_chg[N], m_blink[N], m_tick[N], m_ph[N];

  always @(posedge clk) begin
    for (int p = 0; p < N; p++) begin
      if (!rst_n) begin
        m_s1[p] = 0; m_s2[p] = 0; m_lvl[p] = 0; m_run[p] = 0; m_prev[p] = 0;
        m_pwr[p] = 0; m_chg[p] = 0; m_blink[p] = 0; m_tick[p] = 0; m_ph[p] = 0;
      end else begin
        int rise, old_blink, new_lvl, new_run;
        rise = (m_lvl[p] == 1 && m_prev[p] == 0) ? 1 : 0;
        old_blink = m_blink[p];
        if (m_lvl[p] == 1 || clr_pwr[p] || reenum) m_pwr[p] = 0;
        else if (set_pwr[p] && hub_cfg) m_pwr[p] = 1;
        if (rise == 1) m_chg[p] = 1;
        else if (clr_oc_chg[p]) m_chg[p] = 0;
        if (rise == 1) m_blink[p] = 1;
        else if (clr_pwr[p] || reenum) m_blink[p] = 0;
        if (rise == 1) begin m_tick[p] = 0; m_ph[p] = 1; end
        else if (old_blink == 0) begin m_tick[p] = 0; m_ph[p] = 0; end
        else if (m_tick[p] == H - 1) begin m_tick[p] = 0; m_ph[p] = 1 - m_ph[p]; end
        else m_tick[p] = m_tick[p] + 1;
        new_lvl = m_lvl[p];
        new_run = 0;
        if (m_s2[p] != m_lvl[p]) begin
          if (m_run[p] == F - 1) new_lvl = m_s2[p];
          else new_run = m_run[p] + 1;
        end
        m_prev[p] = m_lvl[p];
        m_lvl[p]  = new_lvl;
        m_run[p]  = new_run;
        m_s2[p]   = m_s1[p];
        m_s1[p]   = oc_in[p] ? 1 : 0;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      for (int p = 0; p < N; p++) begin
        int e_led;
        e_led = (m_blink[p] == 1) ? m_ph[p] : int'(port_en[p]);
        chk(cur_req, $sformatf("pwr_on[%0d]", p), int'(pwr_on[p]), m_pwr[p]);
        chk(cur_req, $sformatf("stat_led[%0d]", p), int'(stat_led[p]), e_led);
        chk(cur_req, $sformatf("oc_status[%0d]", p), int'(oc_status[p]), m_lvl[p]);
        chk(cur_req, $sformatf("oc_change[%0d]", p), int'(oc_change[p]), m_chg[p]);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [N-1:0] m);
    @(negedge clk); set_pwr = m; @(negedge clk); set_pwr = '0;
  endtask
  task automatic pulse_clr(input logic [N-1:0] m);
    @(negedge clk); clr_pwr = m; @(negedge clk); clr_pwr = '0;
  endtask
  task automatic pulse_chg(input logic [N-1:0] m);
    @(negedge clk); clr_oc_chg = m; @(negedge clk); clr_oc_chg = '0;
  endtask
  task automatic pulse_reenum();
    @(negedge clk); reenum = 1'b1; @(negedge clk); reenum = 1'b0;
  endtask

  initial begin
    // R1: reset state
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "all outputs after reset", int'({pwr_on, stat_led, oc_status, oc_change}), 0);

    // R10: indicator follows port_en while not blinking
    cur_req = "R10";
    @(negedge clk); port_en = 4'b0101;
    idle(3);
    chk("R10", "stat_led follows enable", int'(stat_led), 5);
    @(negedge clk); port_en = 4'b0001;
    idle(1);

    // R2: switch-on ignored while unconfigured, honoured once configured
    cur_req = "R2";
    pulse_set(4'b1111);
    idle(2);
    chk("R2", "no power while unconfigured", int'(pwr_on), 0);
    hub_cfg = 1'b1;
    pulse_set(4'b1111);
    idle(1);
    chk("R2", "power after configured switch-on", int'(pwr_on), 15);

    // R3: switch-off, same-cycle set+clear, re-enumeration
    cur_req = "R3";
    pulse_clr(4'b0001);
    idle(1);
    @(negedge clk); set_pwr = 4'b0011; clr_pwr = 4'b0010;
    @(negedge clk); set_pwr = '0; clr_pwr = '0;
    idle(1);
    chk("R3", "clear wins over set", int'(pwr_on), 4'b1101);
    pulse_reenum();
    idle(1);
    chk("R3", "reenum drops all power", int'(pwr_on), 0);
    pulse_set(4'b1111);
    idle(1);

    // R4: a 3-cycle glitch is filtered out
    cur_req = "R4";
    @(negedge clk); oc_in[2] = 1'b1;
    idle(3);
    oc_in[2] = 1'b0;
    idle(10);
    chk("R4", "glitch ignored", int'({oc_status[2], oc_change[2], pwr_on[2]}), 1);

    // R5, R6, R8: held overcurrent on port 2 and port 0 together
    cur_req = "R5";
    @(negedge clk); oc_in = 4'b0101;
    idle(10);
    chk("R5", "overcurrent cuts power", int'(pwr_on & 4'b0101), 0);
    pulse_set(4'b0101);
    idle(2);
    chk("R5", "switch-on ignored during overcurrent", int'(pwr_on & 4'b0101), 0);
    cur_req = "R8";
    idle(30);
    cur_req = "R6";
    @(negedge clk); oc_in = 4'b0000;
    idle(10);
    chk("R6", "status follows released input", int'(oc_status), 0);

    // R7: change bit sticky until cleared; rise wins over same-cycle clear
    cur_req = "R7";
    chk("R7", "change bits still set", int'(oc_change), 5);
    pulse_chg(4'b0001);
    idle(1);
    chk("R7", "port 0 change cleared", int'(oc_change), 4);
    @(negedge clk); oc_in[3] = 1'b1;
    idle(5);
    @(negedge clk); clr_oc_chg[3] = 1'b1;
    @(negedge clk); clr_oc_chg[3] = 1'b0;
    idle(3);

    // R9: switch-off ends blinking on port 2, reenum ends it on port 3
    cur_req = "R9";
    @(negedge clk); port_en = 4'b1100;
    pulse_clr(4'b0100);
    idle(4);
    chk("R9", "port 2 indicator follows enable", int'(stat_led[2]), 1);
    @(negedge clk); oc_in[3] = 1'b0;
    idle(8);
    pulse_reenum();
    idle(4);
    chk("R9", "port 3 indicator follows enable after reenum", int'(stat_led[3]), 1);
    @(negedge clk); port_en = '0;
    idle(2);
    chk("R10", "disabled ports dark", int'(stat_led), 0);

    // R8: a second overcurrent restarts the blink phase
    cur_req = "R8";
    @(negedge clk); oc_in[1] = 1'b1;
    idle(12);
    oc_in[1] = 1'b0;
    idle(8);
    @(negedge clk); oc_in[1] = 1'b1;
    idle(30);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule